// File: doc/BRIEF.md
# Multichannel DAC FIFO Sequencer

This block feeds a bank of up to sixteen DAC channels from one shared sample FIFO. The host loads left-justified 16-bit samples through a data register. It programs a channel-enable mask and picks one of several trigger sources. Each accepted trigger starts a scan. A scan pops one word per enabled channel and writes it to that channel's holding register, visiting the enabled channels from the lowest number upward and spacing the updates by one conversion time. In bipolar mode the two's-complement sample is converted to offset binary for the converter. In unipolar mode the word is passed straight through.

A control/status word sets the trigger source, polarity, reference range, FIFO enable, FIFO wrap and the fill condition that drives the interrupt level. When read, the same word reports a coarse fill code and a busy flag. A read of the data address acts as a software trigger. With wrap enabled, every popped word is written back to the tail, so a loaded waveform plays out repeatedly without host traffic.

Top module: `dac_seq_top`

## Requirements
- R1: After reset the control word reads 0x1000, the word count and channel mask read 0, busy is low, irq is high (interrupt condition 0 = empty), and every holding register and load strobe is 0.
- R2: With the FIFO enabled (control bit 8 = 1), a write to offset 0x0 appends one word, and offset 0x4 reads the current word count. A write is dropped when the FIFO is disabled or already holds DEPTH words.
- R3: Control bits 14:12 read 001 when the FIFO is empty, 000 for 1 to DEPTH/2-1 words, 100 for DEPTH/2 to DEPTH-1 words, and 110 when full.
- R4: irq is a level selected by control bits 11:9: 0 empty, 1 not empty, 2 below half, 3 at or above half, 4 not full, 5 full, 6 and 7 never.
- R5: An accepted trigger pops one word for each channel enabled in the mask at offset 0x6, in FIFO order, to channels in ascending number. The k-th enabled channel (k from 0) is written CONV_CYC*k cycles after the accepting edge, with a one-cycle dac_load pulse for that channel. Channels that are not enabled keep their value.
- R6: Control bits 2:0 select the trigger: 1 = read of offset 0x0, 2 = rising ext_trig, 3 = falling ext_trig, 4/5/6 = rising ctr_out[0]/[1]/[2], 0 and 7 = none. Events from unselected sources are ignored.
- R7: A trigger is dropped, leaving the count and holding registers unchanged, while busy, when the mask is empty, when the FIFO is disabled, or when the FIFO holds fewer words than there are enabled channels.
- R8: busy (port and control bit 15) rises at the accepting edge and stays high for GAP_CYC-1 cycles, so accepted triggers are at least GAP_CYC cycles apart.
- R9: With control bit 3 = 1 (bipolar), a holding register receives the sample with bit 15 inverted. With bit 3 = 0, it receives the sample unchanged.
- R10: With control bit 7 = 1 (wrap), every popped word is re-appended at the tail in the same cycle. The count stays constant and the samples repeat in load order. A host write in a recycling cycle is dropped.
- R11: A control write with bit 12 set empties the FIFO and aborts any scan, while the other bits are stored and bit 12 itself is not. A control write with bit 13 set clears the control word, the mask, the FIFO, the scan and all holding registers.
- R12: Control bits 11:7 and 5:0 read back as written. Bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset; bits 2:1 pick the word register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; at offset 0x0 it may fire a software trigger |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| ext_trig | input | 1 | External trigger line, synchronous to clk |
| ctr_out | input | 3 | Outputs of three external timer counters |
| dac_data | output | NCH*16 | Holding registers, channel n at bits 16n+15:16n |
| dac_load | output | NCH | One-cycle update strobe per channel |
| busy | output | 1 | Scan in progress or spacing window open |
| irq | output | 1 | Selected FIFO fill condition as a level |

## Verification
The bench builds the block with four channels, an eight-word FIFO, a conversion time of two cycles and a scan spacing of eight cycles. With only eight words, the sweep can step the count through every value from empty to full and test all eight interrupt conditions and the fill code at each value. Exact full-FIFO drops also become reachable. The short timings make the per-channel update cycles and the busy window small enough to count exactly, and the small mask lets one scan cover an enabled-disabled-enabled pattern.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [2:0] {
    TRG_OFF      = 3'd0,
    TRG_SW       = 3'd1,
    TRG_EXT_RISE = 3'd2,
    TRG_EXT_FALL = 3'd3,
    TRG_CTR0     = 3'd4,
    TRG_CTR1     = 3'd5,
    TRG_CTR2     = 3'd6,
    TRG_RSVD     = 3'd7
  } trig_sel_e;

  typedef enum logic [1:0] {
    RG_DATA = 2'd0,
    RG_CTRL = 2'd1,
    RG_SIZE = 2'd2,
    RG_CHEN = 2'd3
  } reg_sel_e;

  localparam int CTL_BIPOLAR = 3;
  localparam int CTL_WRAP    = 7;
  localparam int CTL_FIFO_ON = 8;
  localparam int CTL_FLUSH   = 12;
  localparam int CTL_GRESET  = 13;
  // stored control bits: everything in 11:0 except bit 6
  localparam logic [11:0] CTL_KEEP = 12'hFBF;

  // coarse fill code reported in status bits 14:12
  function automatic logic [2:0] fill_code(input int unsigned cnt, input int unsigned depth);
    if (cnt == 0)               return 3'b001;
    else if (cnt < depth / 2)   return 3'b000;
    else if (cnt < depth)       return 3'b100;
    else                        return 3'b110;
  endfunction

  // interrupt level for a given condition selector
  function automatic logic irq_level(input logic [2:0] cond, input int unsigned cnt,
                                     input int unsigned depth);
    case (cond)
      3'd0:    return cnt == 0;
      3'd1:    return cnt != 0;
      3'd2:    return cnt < depth / 2;
      3'd3:    return cnt >= depth / 2;
      3'd4:    return cnt < depth;
      3'd5:    return cnt >= depth;
      default: return 1'b0;
    endcase
  endfunction

  // converter code: two's complement becomes offset binary in bipolar mode
  function automatic logic [15:0] dac_code(input logic [15:0] w, input logic bipolar);
    return w ^ {bipolar, 15'b0};
  endfunction

endpackage

// File: rtl/dseq_fifo.sv
module dseq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4096
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         pop,
  input  logic                         recycle,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt_q;
  logic          recyc, host_ok, wr_any;
  logic [W-1:0]  wdat;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign recyc   = pop && recycle;
  assign host_ok = wr_en && !recyc && (cnt_q != CW'(DEPTH));
  assign wr_any  = recyc || host_ok;
  assign wdat    = recyc ? rd_data : wr_data;
  assign rd_data = mem[rp];
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (wr_any && !flush) mem[wp] <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_any) wp <= next_ptr(wp);
      if (pop)    rp <= next_ptr(rp);
      cnt_q <= cnt_q + CW'(wr_any) - CW'(pop);
    end
  end

endmodule

// File: rtl/dseq_trig.sv
module dseq_trig
  import dseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] sel,
  input  logic       sw_rd,
  input  logic       ext_in,
  input  logic [2:0] ctr_in,
  output logic       fire
);
  logic       ext_prev;
  logic [2:0] ctr_prev;
  logic       ext_rise, ext_fall;
  logic [2:0] ctr_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
      ctr_prev <= '0;
    end else if (clr) begin
      ext_prev <= ext_in;
      ctr_prev <= ctr_in;
    end else begin
      ext_prev <= ext_in;
      ctr_prev <= ctr_in;
    end
  end

  assign ext_rise = ext_in && !ext_prev;
  assign ext_fall = !ext_in && ext_prev;
  assign ctr_rise = ctr_in & ~ctr_prev;

  always_comb begin
    case (trig_sel_e'(sel))
      TRG_SW:       fire = sw_rd;
      TRG_EXT_RISE: fire = ext_rise;
      TRG_EXT_FALL: fire = ext_fall;
      TRG_CTR0:     fire = ctr_rise[0];
      TRG_CTR1:     fire = ctr_rise[1];
      TRG_CTR2:     fire = ctr_rise[2];
      default:      fire = 1'b0;
    endcase
  end

endmodule

// File: rtl/dseq_scan.sv
module dseq_scan
  import dseq_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int CW       = 13,
  parameter int CONV_CYC = 63,
  parameter int GAP_CYC  = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              abort,
  input  logic              fire,
  input  logic [NCH-1:0]    en_mask,
  input  logic              fifo_on,
  input  logic              bipolar,
  input  logic [CW-1:0]     cnt,
  input  logic [15:0]       rd_word,
  output logic              pop,
  output logic              start,
  output logic [NCH*16-1:0] hold_flat,
  output logic [NCH-1:0]    load,
  output logic              busy
);
  localparam int NW   = $clog2(NCH+1);
  localparam int TMAX = (GAP_CYC > CONV_CYC) ? GAP_CYC : CONV_CYC;
  localparam int TW   = $clog2(TMAX+1);

  logic           scan_act;
  logic [NCH-1:0] rem_q;
  logic [TW-1:0]  conv_q, gap_q;
  logic [NW-1:0]  n_req;
  logic           enough, step;
  logic [NCH-1:0] base, tgt, rem_after;
  logic [15:0]    hold_q [NCH];

  function automatic logic [NW-1:0] ones(input logic [NCH-1:0] m);
    logic [NW-1:0] s;
    s = '0;
    for (int i = 0; i < NCH; i++) s = s + NW'(m[i]);
    return s;
  endfunction

  function automatic logic [NCH-1:0] lowest(input logic [NCH-1:0] m);
    return m & (~m + NCH'(1));
  endfunction

  assign n_req     = ones(en_mask);
  assign enough    = 32'(cnt) >= 32'(n_req);
  assign busy      = scan_act || (conv_q != '0) || (gap_q != '0);
  assign start     = fire && !busy && fifo_on && (n_req != '0) && enough && !abort;
  assign step      = scan_act && (conv_q == '0) && !abort;
  assign pop       = start || step;
  assign base      = start ? en_mask : rem_q;
  assign tgt       = lowest(base);
  assign rem_after = base & ~tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_act <= 1'b0;
      rem_q    <= '0;
      conv_q   <= '0;
      gap_q    <= '0;
    end else if (abort || clr) begin
      scan_act <= 1'b0;
      rem_q    <= '0;
      conv_q   <= '0;
      gap_q    <= '0;
    end else if (start) begin
      rem_q    <= rem_after;
      scan_act <= rem_after != '0;
      conv_q   <= TW'(CONV_CYC-1);
      gap_q    <= TW'(GAP_CYC-1);
    end else begin
      if (gap_q != '0) gap_q <= gap_q - TW'(1);
      if (step) begin
        rem_q    <= rem_after;
        scan_act <= rem_after != '0;
        conv_q   <= TW'(CONV_CYC-1);
      end else if (conv_q != '0) begin
        conv_q <= conv_q - TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load <= '0;
      for (int c = 0; c < NCH; c++) hold_q[c] <= '0;
    end else if (clr) begin
      load <= '0;
      for (int c = 0; c < NCH; c++) hold_q[c] <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        load[c] <= pop && tgt[c];
        if (pop && tgt[c]) hold_q[c] <= dac_code(rd_word, bipolar);
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign hold_flat[g*16 +: 16] = hold_q[g];
  end

endmodule

// File: rtl/dac_seq_top.sv
module dac_seq_top
  import dseq_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int DEPTH    = 4096,
  parameter int CONV_CYC = 63,
  parameter int GAP_CYC  = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              ext_trig,
  input  logic [2:0]        ctr_out,
  output logic [NCH*16-1:0] dac_data,
  output logic [NCH-1:0]    dac_load,
  output logic              busy,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH+1);

  reg_sel_e       rsel;
  logic [11:0]    ctrl_q;
  logic [NCH-1:0] chen_q;
  logic           wr_ctrl, wr_chen, host_push, sw_rd;
  logic           glob_clr, fifo_flush, scan_abort;
  logic           trig_fire, scan_start, fifo_pop;
  logic [15:0]    fifo_word;
  logic [CW-1:0]  fifo_cnt;
  logic           wrap_on, fifo_on, bipolar;
  logic           unused_bits;

  assign rsel       = reg_sel_e'(bus_addr[2:1]);
  assign wr_ctrl    = bus_wr && (rsel == RG_CTRL);
  assign wr_chen    = bus_wr && (rsel == RG_CHEN);
  assign glob_clr   = wr_ctrl && bus_wdata[CTL_GRESET];
  assign fifo_flush = wr_ctrl && (bus_wdata[CTL_FLUSH] || bus_wdata[CTL_GRESET]);
  assign scan_abort = fifo_flush;
  assign wrap_on    = ctrl_q[CTL_WRAP];
  assign fifo_on    = ctrl_q[CTL_FIFO_ON];
  assign bipolar    = ctrl_q[CTL_BIPOLAR];
  assign host_push  = bus_wr && (rsel == RG_DATA) && fifo_on;
  assign sw_rd      = bus_rd && (rsel == RG_DATA);
  assign unused_bits = ^{bus_addr[0], bus_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      chen_q <= '0;
    end else if (glob_clr) begin
      ctrl_q <= '0;
      chen_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[11:0] & CTL_KEEP;
      if (wr_chen) chen_q <= bus_wdata[NCH-1:0];
    end
  end

  dseq_fifo #(.W(16), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (fifo_flush),
    .wr_en   (host_push),
    .wr_data (bus_wdata),
    .pop     (fifo_pop),
    .recycle (wrap_on),
    .rd_data (fifo_word),
    .cnt     (fifo_cnt)
  );

  dseq_trig u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (glob_clr),
    .sel    (ctrl_q[2:0]),
    .sw_rd  (sw_rd),
    .ext_in (ext_trig),
    .ctr_in (ctr_out),
    .fire   (trig_fire)
  );

  dseq_scan #(
    .NCH(NCH), .CW(CW), .CONV_CYC(CONV_CYC), .GAP_CYC(GAP_CYC)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (glob_clr),
    .abort     (scan_abort),
    .fire      (trig_fire),
    .en_mask   (chen_q),
    .fifo_on   (fifo_on),
    .bipolar   (bipolar),
    .cnt       (fifo_cnt),
    .rd_word   (fifo_word),
    .pop       (fifo_pop),
    .start     (scan_start),
    .hold_flat (dac_data),
    .load      (dac_load),
    .busy      (busy)
  );

  assign irq = irq_level(ctrl_q[11:9], 32'(fifo_cnt), DEPTH);

  always_comb begin
    case (rsel)
      RG_CTRL: bus_rdata = {busy, fill_code(32'(fifo_cnt), DEPTH), ctrl_q};
      RG_SIZE: bus_rdata = 16'(fifo_cnt);
      RG_CHEN: bus_rdata = 16'(chen_q);
      default: bus_rdata = 16'h0000;
    endcase
  end

endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
  parameter int NCH   = 16,
  parameter int CW    = 13,
  parameter int DEPTH = 4096
) (
  input logic           clk,
  input logic           rst_n,
  input logic           scan_start,
  input logic           fifo_pop,
  input logic           fifo_flush,
  input logic           wrap_on,
  input logic [CW-1:0]  fifo_cnt,
  input logic           busy,
  input logic [NCH-1:0] dac_load
);

  assert_load_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dac_load));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  assert_pop_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_cnt != '0));

  assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_start && !fifo_flush) |=> busy);

  assert_wrap_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_on && fifo_pop && !fifo_flush) |=> (fifo_cnt == $past(fifo_cnt)));

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> ((fifo_cnt == '0) && !busy));

endmodule

bind dac_seq_top dseq_chk #(.NCH(NCH), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_start (scan_start),
  .fifo_pop   (fifo_pop),
  .fifo_flush (fifo_flush),
  .wrap_on    (wrap_on),
  .fifo_cnt   (fifo_cnt),
  .busy       (busy),
  .dac_load   (dac_load)
);

// File: tb/tb_dac_seq_top.sv
`timescale 1ns/1ps
module tb_dac_seq_top;
  localparam int NCH = 4, DEPTH = 8, CONV = 2, GAP = 8;
  localparam logic [2:0] A_DATA = 3'd0, A_CTRL = 3'd2, A_CNT = 3'd4, A_EN = 3'd6;
  localparam logic [15:0] FEN = 16'h0100;

  logic clk = 0, rst_n = 0;
  logic [2:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic ext_trig = 0;
  logic [2:0] ctr_out = 0;
  logic [NCH*16-1:0] dac_data;
  logic [NCH-1:0] dac_load;
  logic busy, irq;

  int errors = 0, checks = 0, cyc = 0, t0 = 0, busy_cnt = 0;
  int load_cyc [NCH];
  bit done = 0;
  logic [15:0] v;

  dac_seq_top #(.NCH(NCH), .DEPTH(DEPTH), .CONV_CYC(CONV), .GAP_CYC(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig), .ctr_out(ctr_out),
    .dac_data(dac_data), .dac_load(dac_load), .busy(busy), .irq(irq));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (busy) busy_cnt++;
    for (int c = 0; c < NCH; c++) if (dac_load[c]) load_cyc[c] = cyc;
  end

  function automatic int exp_code(int n);
    if (n == 0) return 1;
    if (n < DEPTH / 2) return 0;
    if (n < DEPTH) return 4;
    return 6;
  endfunction

  function automatic int exp_irq(int c, int n);
    case (c)
      0: return int'(n == 0);
      1: return int'(n != 0);
      2: return int'(n < DEPTH / 2);
      3: return int'(n >= DEPTH / 2);
      4: return int'(n < DEPTH);
      5: return int'(n == DEPTH);
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic sw_trig();
    @(negedge clk); bus_addr = A_DATA; bus_rd = 1; t0 = cyc + 1;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle();
    repeat (GAP + 4) @(negedge clk);
  endtask

  task automatic pulse_ctr(input int k);
    @(negedge clk); ctr_out[k] = 1;
    @(negedge clk); ctr_out[k] = 0;
    idle();
  endtask

  task automatic rd_cnt(input string tag, input int exp);
    logic [15:0] r;
    bread(A_CNT, r);
    chk(tag, 32'(r), exp);
  endtask

  function automatic logic [15:0] ch(int c);
    return dac_data[c*16 +: 16];
  endfunction

  function automatic logic [15:0] wv(int i);
    return 16'h1000 + 16'(i) * 16'h0101;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    bread(A_CTRL, v); chk("R1 ctrl", 32'(v), 32'h1000);
    rd_cnt("R1 count", 0);
    bread(A_EN, v); chk("R1 mask", 32'(v), 0);
    chk("R1 irq", 32'(irq), 1);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 holding", 32'(dac_data), 0);
    chk("R1 load", 32'(dac_load), 0);
    // R12 readback
    bwrite(A_CTRL, 16'h0FFF);
    bread(A_CTRL, v); chk("R12 readback", 32'(v), 32'h1FBF);
    chk("R4 cond7", 32'(irq), 0);
    // R2 disabled drop
    bwrite(A_CTRL, 16'h0000);
    bwrite(A_DATA, 16'h5555);
    rd_cnt("R2 disabled drop", 0);
    // R2/R3/R4 sweep over every fill level and every interrupt condition
    for (int n = 0; n <= DEPTH; n++) begin
      bwrite(A_CTRL, FEN);
      if (n > 0) bwrite(A_DATA, wv(n - 1));
      rd_cnt("R2 count", n);
      bread(A_CTRL, v); chk("R3 fill code", 32'(v[14:12]), exp_code(n));
      for (int c = 0; c < 8; c++) begin
        bwrite(A_CTRL, FEN | 16'(c << 9));
        chk($sformatf("R4 cond%0d n=%0d", c, n), 32'(irq), exp_irq(c, n));
      end
    end
    bwrite(A_DATA, 16'hDEAD);
    rd_cnt("R2 full drop", DEPTH);
    // R5 scan order and timing, mask 1011
    bwrite(A_EN, 16'h000B);
    bwrite(A_CTRL, FEN | 16'h1);
    for (int c = 0; c < NCH; c++) load_cyc[c] = -1;
    busy_cnt = 0;
    sw_trig(); idle();
    chk("R5 ch0", 32'(ch(0)), 32'(wv(0)));
    chk("R5 ch1", 32'(ch(1)), 32'(wv(1)));
    chk("R5 ch2 kept", 32'(ch(2)), 0);
    chk("R5 ch3", 32'(ch(3)), 32'(wv(2)));
    chk("R5 t ch0", load_cyc[0], t0);
    chk("R5 t ch1", load_cyc[1], t0 + CONV);
    chk("R5 t ch2", load_cyc[2], -1);
    chk("R5 t ch3", load_cyc[3], t0 + 2 * CONV);
    chk("R8 busy span", busy_cnt, GAP - 1);
    rd_cnt("R5 count", DEPTH - 3);
    // R7 busy drop, R8 status bit
    sw_trig();
    bread(A_CTRL, v); chk("R8 status busy", 32'(v[15]), 1);
    sw_trig(); idle();
    chk("R7 busy ch0", 32'(ch(0)), 32'(wv(3)));
    chk("R7 busy ch3", 32'(ch(3)), 32'(wv(5)));
    rd_cnt("R7 busy drop", 2);
    // R7 too few words
    bwrite(A_EN, 16'h000F); sw_trig(); idle();
    rd_cnt("R7 short", 2);
    chk("R7 short ch0", 32'(ch(0)), 32'(wv(3)));
    // R7 empty mask
    bwrite(A_EN, 16'h0000); sw_trig(); idle();
    rd_cnt("R7 empty mask", 2);
    // R7 fifo disabled
    bwrite(A_EN, 16'h0001); bwrite(A_CTRL, 16'h0001); sw_trig(); idle();
    rd_cnt("R7 disabled", 2);
    chk("R7 disabled ch0", 32'(ch(0)), 32'(wv(3)));
    // R6 none selected
    bwrite(A_CTRL, FEN); sw_trig(); idle();
    rd_cnt("R6 none", 2);
    // R6 external rising
    bwrite(A_CTRL, FEN | 16'h2);
    @(negedge clk); ext_trig = 1; idle();
    chk("R6 ext rise ch0", 32'(ch(0)), 32'(wv(6)));
    rd_cnt("R6 ext rise count", 1);
    @(negedge clk); ext_trig = 0; idle();
    rd_cnt("R6 fall ignored", 1);
    // R11 flush
    bwrite(A_CTRL, FEN | 16'h1000 | 16'h2);
    rd_cnt("R11 flush", 0);
    for (int i = 0; i < 4; i++) bwrite(A_DATA, 16'h2000 + 16'(i));
    bread(A_CTRL, v);
    chk("R11 flush bit not stored", 32'(v[14:12]), 4);
    chk("R11 other bits stored", 32'(v[11:0]), 32'h102);
    // R6 external falling
    bwrite(A_CTRL, FEN | 16'h3);
    @(negedge clk); ext_trig = 1; idle();
    rd_cnt("R6 rise ignored", 4);
    @(negedge clk); ext_trig = 0; idle();
    rd_cnt("R6 ext fall count", 3);
    chk("R6 ext fall ch0", 32'(ch(0)), 32'h2000);
    // R6 counters
    bwrite(A_CTRL, FEN | 16'h5);
    pulse_ctr(0); pulse_ctr(2);
    rd_cnt("R6 other ctr ignored", 3);
    pulse_ctr(1);
    chk("R6 ctr1", 32'(ch(0)), 32'h2001);
    bwrite(A_CTRL, FEN | 16'h4); pulse_ctr(0);
    chk("R6 ctr0", 32'(ch(0)), 32'h2002);
    bwrite(A_CTRL, FEN | 16'h6); pulse_ctr(2);
    chk("R6 ctr2", 32'(ch(0)), 32'h2003);
    rd_cnt("R6 ctr count", 0);
    // R9 polarity
    bwrite(A_DATA, 16'h1234); bwrite(A_DATA, 16'h8000); bwrite(A_DATA, 16'h7FFF);
    bwrite(A_CTRL, FEN | 16'h8 | 16'h1);
    sw_trig(); idle(); chk("R9 bipolar a", 32'(ch(0)), 32'h9234);
    sw_trig(); idle(); chk("R9 bipolar b", 32'(ch(0)), 32'h0000);
    bwrite(A_CTRL, FEN | 16'h1);
    sw_trig(); idle(); chk("R9 unipolar", 32'(ch(0)), 32'h7FFF);
    // R10 wrap
    bwrite(A_CTRL, FEN | 16'h80 | 16'h1);
    for (int i = 0; i < 3; i++) bwrite(A_DATA, 16'h3000 + 16'(i * 16'h11));
    for (int k = 0; k < 5; k++) begin
      sw_trig(); idle();
      chk("R10 wrap data", 32'(ch(0)), 32'h3000 + 32'((k % 3) * 16'h11));
      rd_cnt("R10 wrap count", 3);
    end
    // R11 global reset
    bwrite(A_EN, 16'h000F);
    bwrite(A_CTRL, 16'h2000);
    bread(A_CTRL, v); chk("R11 global ctrl", 32'(v), 32'h1000);
    bread(A_EN, v); chk("R11 global mask", 32'(v), 0);
    rd_cnt("R11 global count", 0);
    chk("R11 global holding", 32'(dac_data), 0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule